// File: doc/BRIEF.md
# Open-Row-First DRAM Request Scheduler

This block queues pending read requests for a single DRAM channel with one rank and decides which one goes to memory next. Each request carries a 32-bit byte address and an identifier chosen by the requester. On arrival the address is split into row, bank and column fields. The scheduler keeps a record of the open row in every bank and of whether each bank is still servicing an earlier request.

At most one request is issued per issue slot. A request qualifies only if its bank is idle. Among the qualifying requests, one that targets the row already open in its bank is preferred. The oldest request breaks every remaining tie. Service time is modelled per bank: a short latency when the row is already open, and a long latency when another row is open or the bank has never been opened. Banks count down in parallel. Each bank has its own completion lane, which pulses with the finished request's identifier.

Top module: `frfcfs_sched`

## Requirements
- R1: After reset the queue is empty (`enqReady` high), nothing is issued, no completion lane pulses, and every bank is treated as closed.
- R2: With default parameters the address fields are row = addr[31:14], bank = addr[13:11] and column = addr[10:6]. Bits [5:0] are the byte within a 64-byte line and are ignored. `issRow`, `issBank` and `issCol` report the issued request's fields.
- R3: A request issued to a bank whose open row equals its row has `issHit` = 1, and its completion pulse appears exactly 50 cycles after the issue cycle.
- R4: A request issued to a closed bank, or to a bank with a different open row, has `issHit` = 0, and its completion pulse appears exactly 250 cycles after the issue cycle.
- R5: A request that hits an open row is issued before an older eligible request that does not.
- R6: Among eligible requests of equal hit status, the oldest is issued first.
- R7: A request whose bank is still servicing is not issued before that bank's completion cycle. Requests to different banks are serviced at the same time.
- R8: Two issues are never closer than 10 cycles apart. When eligible work is waiting, the next issue happens exactly 10 cycles after the previous one.
- R9: While `memReady` is low, nothing is issued.
- R10: With 4 requests queued, `enqReady` is low, and a request offered in that state is dropped and never issued.
- R11: After any access, the accessed row stays open in its bank, so a later request to that row is a hit.
- R12: A completion pulses on lane `doneValid[b]`, where b is the request's bank. The request's identifier appears on `doneTag[b*4 +: 4]` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| enqValid | input | 1 | A new request is offered this cycle |
| enqAddr | input | ADDR_W (32) | Byte address of the offered request |
| enqTag | input | ID_W (4) | Identifier of the offered request |
| enqReady | output | 1 | Queue has room; the offer is taken at the clock edge |
| memReady | input | 1 | Memory side accepts an issue this cycle |
| issValid | output | 1 | A request is issued this cycle |
| issTag | output | ID_W (4) | Identifier of the issued request |
| issBank | output | BANK_W (3) | Bank of the issued request |
| issRow | output | ROW_W (18) | Row of the issued request |
| issCol | output | COL_W (5) | Column of the issued request |
| issHit | output | 1 | The issued request hits its bank's open row |
| doneValid | output | NUM_BANKS (8) | Per-bank completion pulse |
| doneTag | output | NUM_BANKS*ID_W (32) | Per-bank identifier of the completing request |

## Verification
The assertions assume a well-behaved requester. An offer counts as taken only when `enqValid` and `enqReady` are both high. The checker keeps its own occupancy and per-bank elapsed-time counters from the port activity alone, so it relies on every issue being visible on `issValid` in the cycle it happens. The stimulus drives offers and `memReady` only between clock edges, gives every request a distinct identifier within a test, and applies reset between tests. Identifiers are never reused while a request is still in flight, so the per-identifier records stay unambiguous.

// File: rtl/frfcfs_pkg.sv
package frfcfs_pkg;
  // Strobes passed from the control module to the datapath each cycle.
  typedef struct packed {
    logic doEnq;     // accept the offered request into the queue tail
    logic doIssue;   // remove the picked request and start its bank
  } ctrlStrb_t;
endpackage

// File: rtl/frfcfs_ctrl.sv
module frfcfs_ctrl
  import frfcfs_pkg::*;
#(
  parameter int SLOT_CYCLES = 10,
  localparam int SLOT_W = $clog2(SLOT_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enqValid,
  input  logic       qFull,
  input  logic       memReady,
  input  logic       anyElig,
  output ctrlStrb_t  strb
);

  logic [SLOT_W-1:0] slotCnt;
  logic              slotOpen;

  assign slotOpen = (slotCnt == '0);

  always_comb begin
    strb.doIssue = slotOpen && memReady && anyElig;
    strb.doEnq   = enqValid && !qFull;
  end

  // Cool-down between issues: loaded with SLOT_CYCLES-1 on an issue, so the
  // earliest following issue is SLOT_CYCLES cycles later.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt <= '0;
    end else if (strb.doIssue) begin
      slotCnt <= SLOT_W'(SLOT_CYCLES - 1);
    end else if (!slotOpen) begin
      slotCnt <= slotCnt - 1'b1;
    end
  end

endmodule

// File: rtl/frfcfs_datapath.sv
module frfcfs_datapath
  import frfcfs_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int LINE_BYTES   = 64,
  parameter int COLS_PER_ROW = 32,
  parameter int NUM_BANKS    = 8,
  parameter int QDEPTH       = 4,
  parameter int ID_W         = 4,
  parameter int HIT_LAT      = 50,
  parameter int MISS_LAT     = 250,
  localparam int OFF_W    = $clog2(LINE_BYTES),
  localparam int COL_W    = $clog2(COLS_PER_ROW),
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ROW_W    = ADDR_W - OFF_W - COL_W - BANK_W,
  localparam int COL_LSB  = OFF_W,
  localparam int BANK_LSB = OFF_W + COL_W,
  localparam int ROW_LSB  = OFF_W + COL_W + BANK_W,
  localparam int IDX_W    = $clog2(QDEPTH),
  localparam int QCNT_W   = $clog2(QDEPTH + 1),
  localparam int LAT_W    = $clog2(HIT_LAT + MISS_LAT + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrb_t                   strb,
  input  logic [ADDR_W-1:0]           enqAddr,
  input  logic [ID_W-1:0]             enqTag,
  output logic                        qFull,
  output logic                        anyElig,
  output logic [ID_W-1:0]             pickTag,
  output logic [BANK_W-1:0]           pickBank,
  output logic [ROW_W-1:0]            pickRow,
  output logic [COL_W-1:0]            pickCol,
  output logic                        pickHit,
  output logic [NUM_BANKS-1:0]        doneValid,
  output logic [NUM_BANKS*ID_W-1:0]   doneTag
);

  // ---------------- request queue (index 0 is the oldest) ----------------
  logic [BANK_W-1:0] qBank [QDEPTH];
  logic [ROW_W-1:0]  qRow  [QDEPTH];
  logic [COL_W-1:0]  qCol  [QDEPTH];
  logic [ID_W-1:0]   qTag  [QDEPTH];
  logic [QCNT_W-1:0] qCount;

  logic [BANK_W-1:0] nBank [QDEPTH];
  logic [ROW_W-1:0]  nRow  [QDEPTH];
  logic [COL_W-1:0]  nCol  [QDEPTH];
  logic [ID_W-1:0]   nTag  [QDEPTH];
  logic [QCNT_W-1:0] nCount;
  logic [QCNT_W-1:0] cntAfterIssue;

  // Byte-within-line bits carry no scheduling meaning.
  logic unusedOffBits;
  assign unusedOffBits = ^enqAddr[OFF_W-1:0];

  // ---------------- per-bank state ----------------
  logic [NUM_BANKS-1:0] bankFree;
  logic [NUM_BANKS-1:0] bankOpen;
  logic [ROW_W-1:0]     bankRow [NUM_BANKS];

  // ---------------- per-entry qualification ----------------
  logic [QDEPTH-1:0] eElig;
  logic [QDEPTH-1:0] eHit;
  logic [IDX_W-1:0]  pickIdx;

  assign qFull = (qCount == QCNT_W'(QDEPTH));

  for (genvar e = 0; e < QDEPTH; e++) begin : g_entry
    assign eElig[e] = (QCNT_W'(e) < qCount) && bankFree[qBank[e]];
    assign eHit[e]  = bankOpen[qBank[e]] && (bankRow[qBank[e]] == qRow[e]);
  end

  // Two priority searches: oldest eligible hit, else oldest eligible.
  always_comb begin
    logic             hitFound;
    logic [IDX_W-1:0] hitIdx;
    logic [IDX_W-1:0] oldIdx;
    hitFound = 1'b0;
    hitIdx   = '0;
    oldIdx   = '0;
    anyElig  = 1'b0;
    for (int i = QDEPTH - 1; i >= 0; i--) begin
      if (eElig[i]) begin
        oldIdx  = IDX_W'(i);
        anyElig = 1'b1;
        if (eHit[i]) begin
          hitIdx   = IDX_W'(i);
          hitFound = 1'b1;
        end
      end
    end
    pickIdx = hitFound ? hitIdx : oldIdx;
  end

  assign pickTag  = qTag[pickIdx];
  assign pickBank = qBank[pickIdx];
  assign pickRow  = qRow[pickIdx];
  assign pickCol  = qCol[pickIdx];
  assign pickHit  = eHit[pickIdx];

  // Collapse the picked slot, then append the accepted request at the tail.
  always_comb begin
    logic [IDX_W-1:0] src;
    for (int i = 0; i < QDEPTH; i++) begin
      src = IDX_W'(i);
      if (strb.doIssue && (IDX_W'(i) >= pickIdx) && (i < QDEPTH - 1)) begin
        src = IDX_W'(i + 1);
      end
      nBank[i] = qBank[src];
      nRow[i]  = qRow[src];
      nCol[i]  = qCol[src];
      nTag[i]  = qTag[src];
    end
    cntAfterIssue = qCount - (strb.doIssue ? QCNT_W'(1) : QCNT_W'(0));
    if (strb.doEnq) begin
      nBank[cntAfterIssue[IDX_W-1:0]] = enqAddr[BANK_LSB +: BANK_W];
      nRow[cntAfterIssue[IDX_W-1:0]]  = enqAddr[ROW_LSB +: ROW_W];
      nCol[cntAfterIssue[IDX_W-1:0]]  = enqAddr[COL_LSB +: COL_W];
      nTag[cntAfterIssue[IDX_W-1:0]]  = enqTag;
    end
    nCount = cntAfterIssue + (strb.doEnq ? QCNT_W'(1) : QCNT_W'(0));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qCount <= '0;
      for (int i = 0; i < QDEPTH; i++) begin
        qBank[i] <= '0;
        qRow[i]  <= '0;
        qCol[i]  <= '0;
        qTag[i]  <= '0;
      end
    end else begin
      qCount <= nCount;
      for (int i = 0; i < QDEPTH; i++) begin
        qBank[i] <= nBank[i];
        qRow[i]  <= nRow[i];
        qCol[i]  <= nCol[i];
        qTag[i]  <= nTag[i];
      end
    end
  end

  // ---------------- one service timer per bank ----------------
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [LAT_W-1:0] busyCnt;
    logic [ID_W-1:0]  curTag;
    logic             issueHere;

    assign issueHere = strb.doIssue && (pickBank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        busyCnt     <= '0;
        curTag      <= '0;
        bankOpen[b] <= 1'b0;
        bankRow[b]  <= '0;
      end else if (issueHere) begin
        busyCnt     <= pickHit ? LAT_W'(HIT_LAT) : LAT_W'(MISS_LAT);
        curTag      <= pickTag;
        bankOpen[b] <= 1'b1;
        bankRow[b]  <= pickRow;
      end else if (busyCnt != '0) begin
        busyCnt <= busyCnt - 1'b1;
      end
    end

    // The final service cycle is also the first cycle a new request may go.
    assign bankFree[b]               = (busyCnt <= LAT_W'(1));
    assign doneValid[b]              = (busyCnt == LAT_W'(1));
    assign doneTag[b*ID_W +: ID_W]   = curTag;
  end

endmodule

// File: rtl/frfcfs_sched.sv
module frfcfs_sched
  import frfcfs_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int LINE_BYTES   = 64,
  parameter int COLS_PER_ROW = 32,
  parameter int NUM_BANKS    = 8,
  parameter int QDEPTH       = 4,
  parameter int ID_W         = 4,
  parameter int HIT_LAT      = 50,
  parameter int MISS_LAT     = 250,
  parameter int SLOT_CYCLES  = 10,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int COL_W  = $clog2(COLS_PER_ROW),
  localparam int ROW_W  = ADDR_W - $clog2(LINE_BYTES) - COL_W - BANK_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       enqValid,
  input  logic [ADDR_W-1:0]          enqAddr,
  input  logic [ID_W-1:0]            enqTag,
  output logic                       enqReady,
  input  logic                       memReady,
  output logic                       issValid,
  output logic [ID_W-1:0]            issTag,
  output logic [BANK_W-1:0]          issBank,
  output logic [ROW_W-1:0]           issRow,
  output logic [COL_W-1:0]           issCol,
  output logic                       issHit,
  output logic [NUM_BANKS-1:0]       doneValid,
  output logic [NUM_BANKS*ID_W-1:0]  doneTag
);

  ctrlStrb_t strb;
  logic      qFull;
  logic      anyElig;

  frfcfs_ctrl #(
    .SLOT_CYCLES (SLOT_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enqValid (enqValid),
    .qFull    (qFull),
    .memReady (memReady),
    .anyElig  (anyElig),
    .strb     (strb)
  );

  frfcfs_datapath #(
    .ADDR_W       (ADDR_W),
    .LINE_BYTES   (LINE_BYTES),
    .COLS_PER_ROW (COLS_PER_ROW),
    .NUM_BANKS    (NUM_BANKS),
    .QDEPTH       (QDEPTH),
    .ID_W         (ID_W),
    .HIT_LAT      (HIT_LAT),
    .MISS_LAT     (MISS_LAT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .enqAddr   (enqAddr),
    .enqTag    (enqTag),
    .qFull     (qFull),
    .anyElig   (anyElig),
    .pickTag   (issTag),
    .pickBank  (issBank),
    .pickRow   (issRow),
    .pickCol   (issCol),
    .pickHit   (issHit),
    .doneValid (doneValid),
    .doneTag   (doneTag)
  );

  assign enqReady = !qFull;
  assign issValid = strb.doIssue;

endmodule

// File: rtl/frfcfs_checker.sv
module frfcfs_checker #(
  parameter int NUM_BANKS   = 8,
  parameter int QDEPTH      = 4,
  parameter int HIT_LAT     = 50,
  parameter int MISS_LAT    = 250,
  parameter int SLOT_CYCLES = 10,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 enqValid,
  input logic                 enqReady,
  input logic                 memReady,
  input logic                 issValid,
  input logic [BANK_W-1:0]    issBank,
  input logic                 issHit,
  input logic [NUM_BANKS-1:0] doneValid
);

  logic [15:0]          sinceIssue;
  logic                 sawIssue;
  logic [15:0]          occ;
  logic [NUM_BANKS-1:0] everOpened;
  logic [NUM_BANKS-1:0] laneBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceIssue <= '0;
      sawIssue   <= 1'b0;
      occ        <= '0;
      everOpened <= '0;
    end else begin
      if (issValid) begin
        sinceIssue          <= 16'd1;
        sawIssue            <= 1'b1;
        everOpened[issBank] <= 1'b1;
      end else if (sinceIssue != 16'hFFFF) begin
        sinceIssue <= sinceIssue + 16'd1;
      end
      occ <= occ + ((enqValid && enqReady) ? 16'd1 : 16'd0)
                 - (issValid ? 16'd1 : 16'd0);
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lane
    logic        act;
    logic [15:0] elapsed;
    logic [15:0] expLat;
    logic        issHere;
    assign issHere = issValid && (issBank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        act     <= 1'b0;
        elapsed <= '0;
        expLat  <= '0;
      end else if (issHere) begin
        act     <= 1'b1;
        elapsed <= 16'd1;
        expLat  <= issHit ? 16'(HIT_LAT) : 16'(MISS_LAT);
      end else if (act) begin
        if (doneValid[b]) act <= 1'b0;
        elapsed <= elapsed + 16'd1;
      end
    end

    assign laneBusy[b] = act && !doneValid[b];

    AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rstN)
      doneValid[b] |-> (act && elapsed == expLat)) else $error("completion off schedule"); // R3
    AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (!rstN)
      (act && elapsed < expLat) |-> !doneValid[b]) else $error("completion too early"); // R4
  end

  AST_ISSUE_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (issValid && sawIssue) |-> (sinceIssue >= 16'(SLOT_CYCLES))) else $error("issues too close"); // R8
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !memReady |-> !issValid) else $error("issue while stalled"); // R9
  AST_READY_MATCHES_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    enqReady == (occ < 16'(QDEPTH))) else $error("ready disagrees with occupancy"); // R10
  AST_ISSUE_HAS_WORK: assert property (@(posedge clk) disable iff (!rstN)
    issValid |-> (occ != 16'd0)) else $error("issue from empty queue"); // R1
  AST_BANK_IDLE_ON_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    issValid |-> !laneBusy[issBank]) else $error("issue to busy bank"); // R7
  AST_CLOSED_IS_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (issValid && !everOpened[issBank]) |-> !issHit) else $error("hit on closed bank"); // R4

endmodule

bind frfcfs_sched frfcfs_checker #(
  .NUM_BANKS   (NUM_BANKS),
  .QDEPTH      (QDEPTH),
  .HIT_LAT     (HIT_LAT),
  .MISS_LAT    (MISS_LAT),
  .SLOT_CYCLES (SLOT_CYCLES)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .enqValid  (enqValid),
  .enqReady  (enqReady),
  .memReady  (memReady),
  .issValid  (issValid),
  .issBank   (issBank),
  .issHit    (issHit),
  .doneValid (doneValid)
);

// File: tb/tb_frfcfs_sched.sv
module tb_frfcfs_sched;
  localparam int NB  = 8;
  localparam int IDW = 4;
  localparam int NT  = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            enqValid = 1'b0;
  logic [31:0]     enqAddr = '0;
  logic [IDW-1:0]  enqTag = '0;
  logic            enqReady;
  logic            memReady = 1'b1;
  logic            issValid;
  logic [IDW-1:0]  issTag;
  logic [2:0]      issBank;
  logic [17:0]     issRow;
  logic [4:0]      issCol;
  logic            issHit;
  logic [NB-1:0]   doneValid;
  logic [NB*IDW-1:0] doneTag;

  always #4 clk = ~clk;

  frfcfs_sched dut (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqAddr(enqAddr),
    .enqTag(enqTag), .enqReady(enqReady), .memReady(memReady),
    .issValid(issValid), .issTag(issTag), .issBank(issBank),
    .issRow(issRow), .issCol(issCol), .issHit(issHit),
    .doneValid(doneValid), .doneTag(doneTag)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  int issCount;
  int issCyc [NT];
  int issBankR [NT];
  int issRowR [NT];
  int issColR [NT];
  int issHitR [NT];
  int issOrd [NT];
  int doneCyc [NT];
  int doneLane [NT];

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: records issue and completion events per identifier.
  always @(negedge clk) begin
    if (rstN) begin
      if (issValid) begin
        issCyc[issTag]   = cyc;
        issBankR[issTag] = int'(issBank);
        issRowR[issTag]  = int'(issRow);
        issColR[issTag]  = int'(issCol);
        issHitR[issTag]  = int'(issHit);
        if (issCount < NT) issOrd[issCount] = int'(issTag);
        issCount = issCount + 1;
      end
      for (int b = 0; b < NB; b++) begin
        if (doneValid[b]) begin
          doneCyc[doneTag[b*IDW +: IDW]]  = cyc;
          doneLane[doneTag[b*IDW +: IDW]] = b;
        end
      end
    end
  end

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkAddr(int row, int bank, int col);
    return (32'(row) << 14) | (32'(bank) << 11) | (32'(col) << 6) | 32'h2A;
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    enqValid = 1'b0;
    memReady = 1'b1;
    issCount = 0;
    for (int i = 0; i < NT; i++) begin
      issCyc[i] = -1; doneCyc[i] = -1; doneLane[i] = -1; issOrd[i] = -1;
      issBankR[i] = -1; issRowR[i] = -1; issColR[i] = -1; issHitR[i] = -1;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic enq(logic [31:0] addr, int tag, output int accepted);
    enqValid = 1'b1;
    enqAddr  = addr;
    enqTag   = IDW'(tag);
    accepted = int'(enqReady);
    @(negedge clk);
    enqValid = 1'b0;
  endtask

  task automatic waitDone(int tag);
    for (int n = 0; n < 2000 && doneCyc[tag] < 0; n++) @(negedge clk);
  endtask

  // Vector table: row, bank, column, expected hit (sequential, one at a time).
  localparam int NV = 7;
  localparam int VEC [NV][4] = '{
    '{5,      3, 0,  0},
    '{5,      3, 7,  1},
    '{6,      3, 7,  0},
    '{6,      0, 2,  0},
    '{6,      0, 9,  1},
    '{262143, 7, 31, 0},
    '{262143, 7, 0,  1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int acc;
    doReset();

    // R1: reset state
    check("R1 enqReady after reset", int'(enqReady), 1);
    check("R1 no issue after reset", int'(issValid), 0);
    check("R1 no completion after reset", int'(doneValid), 0);

    // Table walk: R2 decode, R3/R4 latency, R11 open row, R12 lane
    for (int v = 0; v < NV; v++) begin
      enq(mkAddr(VEC[v][0], VEC[v][1], VEC[v][2]), v, acc);
      waitDone(v);
      check("R2 issued bank", issBankR[v], VEC[v][1]);
      check("R2 issued row", issRowR[v], VEC[v][0]);
      check("R2 issued column", issColR[v], VEC[v][2]);
      check("R11 hit status", issHitR[v], VEC[v][3]);
      check(VEC[v][3] != 0 ? "R3 hit latency" : "R4 conflict latency",
            doneCyc[v] - issCyc[v], VEC[v][3] != 0 ? 50 : 250);
      check("R12 completion lane", doneLane[v], VEC[v][1]);
    end

    // R5 / R7: younger hit overtakes older conflict in the same bank
    doReset();
    enq(mkAddr(1, 1, 0), 0, acc);
    waitDone(0);
    memReady = 1'b0;
    enq(mkAddr(2, 1, 0), 1, acc);
    enq(mkAddr(1, 1, 3), 2, acc);
    memReady = 1'b1;
    waitDone(1);
    check("R5 hit issued first", issOrd[1], 2);
    check("R5 older conflict issued second", issOrd[2], 1);
    check("R5 younger is hit", issHitR[2], 1);
    check("R7 waits for bank completion", issCyc[1] - issCyc[2], 50);

    // R6 / R8 / R7: two closed banks, oldest first, parallel service
    doReset();
    memReady = 1'b0;
    enq(mkAddr(4, 2, 0), 3, acc);
    enq(mkAddr(9, 5, 0), 4, acc);
    memReady = 1'b1;
    waitDone(4);
    check("R6 oldest first", issOrd[0], 3);
    check("R8 slot spacing", issCyc[4] - issCyc[3], 10);
    check("R7 parallel completion", doneCyc[4] - doneCyc[3], 10);

    // R9: stalled memory side
    doReset();
    memReady = 1'b0;
    enq(mkAddr(1, 6, 0), 6, acc);
    repeat (30) @(negedge clk);
    check("R9 no issue while stalled", issCount, 0);
    memReady = 1'b1;
    waitDone(6);
    check("R9 issue after release", issCount, 1);

    // R10: full queue drops a further offer
    doReset();
    memReady = 1'b0;
    for (int i = 0; i < 4; i++) enq(mkAddr(3, i, 0), 7 + i, acc);
    check("R10 not ready when full", int'(enqReady), 0);
    enq(mkAddr(3, 6, 0), 11, acc);
    check("R10 offer refused", acc, 0);
    memReady = 1'b1;
    waitDone(10);
    repeat (20) @(negedge clk);
    check("R10 only queued requests issued", issCount, 4);
    check("R10 dropped request never issued", issCyc[11], -1);
    check("R6 arrival order kept", issOrd[3], 10);
    check("R8 back-to-back spacing", issCyc[10] - issCyc[7], 30);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule